// File: doc/BRIEF.md
# Dual-Channel Serial DAC Write Adapter

This block takes an 8-bit sample from the parallel side, tags it with a control byte that names one of two DAC channels, and sends the 16-bit result to a dual voltage-output DAC. The link has three wires: an active-low frame line, a serial clock and serial data. The serial clock runs at half the system clock, so a 50 MHz system clock gives a 25 MHz serial clock. One transfer takes 34 system cycles (680 ns), which allows about 1.47 million updates per second.

The parallel side watches `busy` and pulses `wr_stb` when it has a sample. The adapter captures the channel select, the configuration byte and the sample on the edge where it accepts the strobe. The user may then change those inputs freely. The control byte is the configuration byte with one bit, at position `CHAN_BIT` (default 2), replaced by the channel select.

Top module: `dac_ser_adapter`

## Requirements
- R1: After a synchronous reset, `frame_n` is 1, `sclk` is 0, `sdout` is 0 and `busy` is 0.
- R2: A transfer sends one 16-bit word, most significant bit first: the control byte in bits 15..8, then the sample in bits 7..0. Each bit is valid at a rising `sclk` edge.
- R3: The control byte equals `cfg_in` with bit 2 replaced by `chan_sel`. Channel A is 0 and channel B is 1. The other seven bits pass through unchanged.
- R4: Within a frame, `sclk` toggles on every system clock. It makes exactly 16 rising edges, and each high phase lasts one system cycle.
- R5: `sdout` changes only on a falling `sclk` edge, or on the cycle in which `frame_n` falls.
- R6: `frame_n` stays low for exactly 33 system cycles per transfer. With `wr_stb` held high, a new frame starts every 34 cycles.
- R7: `busy` rises together with the fall of `frame_n` and drops together with its return high. It stays high for 33 cycles.
- R8: A strobe that arrives while `busy` is high is ignored. Input changes during a transfer do not alter the word being sent, and the frame keeps its length.
- R9: While idle, `sclk` stays 0 and `frame_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write request, taken when `busy` is low |
| chan_sel | input | 1 | Target channel, placed in control bit 2 |
| cfg_in | input | 8 | Static control byte bits (bit 2 ignored) |
| data_in | input | 8 | Sample for the DAC |
| busy | output | 1 | High while a transfer is in progress |
| frame_n | output | 1 | Active-low frame sync to the DAC |
| sclk | output | 1 | Serial clock, half the system clock |
| sdout | output | 1 | Serial data, MSB first |

## Verification
The bench sends words whose patterns tell different faults apart. Alternating bits expose slipped or doubled shifts. Single set bits at either end show the bit order and the first and last bit positions. All-ones and all-zeros show stuck data. Each configuration byte is sent with both channel selects, which separates the channel bit from its neighbours. A transfer that is disturbed mid-frame by a new strobe and new inputs shows whether the adapter captures its inputs at acceptance. A held strobe measures the back-to-back period.

// File: rtl/dac_adapter_pkg.sv
package dac_adapter_pkg;
  // cycles frame_n stays low for a word of w bits: two per bit plus one hold
  function automatic int frame_low_cycles(input int w);
    return 2 * w + 1;
  endfunction
endpackage

// File: rtl/dac_word_pack.sv
module dac_word_pack #(
  parameter int CTRL_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CHAN_BIT = 2,
  localparam int WORD_W  = CTRL_W + DATA_W
) (
  input  logic              chan_sel,
  input  logic [CTRL_W-1:0] cfg_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [WORD_W-1:0] word
);
  logic [CTRL_W-1:0] ctrl;

  for (genvar i = 0; i < CTRL_W; i++) begin : g_ctrl
    if (i == CHAN_BIT) begin : g_chan
      assign ctrl[i] = chan_sel;
    end else begin : g_cfg
      assign ctrl[i] = cfg_in[i];
    end
  end

  assign word = {ctrl, data_in};
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl #(
  parameter int WORD_W  = 16,
  localparam int LAST   = 2 * WORD_W,
  localparam int STEP_W = $clog2(LAST + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  output logic load,
  output logic shift_en,
  output logic busy,
  output logic frame_n,
  output logic sclk
);
  logic [STEP_W-1:0] step;

  assign load     = wr_stb && !busy;
  assign shift_en = busy && step[0] && (step < STEP_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      frame_n <= 1'b1;
      sclk    <= 1'b0;
      step    <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      frame_n <= 1'b0;
      sclk    <= 1'b0;
      step    <= '0;
    end else if (busy) begin
      step <= step + 1'b1;
      if (step < STEP_W'(LAST)) sclk <= ~sclk;
      if (step == STEP_W'(LAST)) begin
        busy    <= 1'b0;
        frame_n <= 1'b1;
        sclk    <= 1'b0;
      end
    end
  end

  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> step <= STEP_W'(LAST));
endmodule

// File: rtl/dac_shift_out.sv
module dac_shift_out #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] word_in,
  output logic              sdout
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      sdout <= 1'b0;
    end else if (load) begin
      sdout <= word_in[WORD_W-1];
      sreg  <= {word_in[WORD_W-2:0], 1'b0};
    end else if (shift_en) begin
      sdout <= sreg[WORD_W-1];
      sreg  <= {sreg[WORD_W-2:0], 1'b0};
    end
  end

  // R2
  shift_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && shift_en));
endmodule

// File: rtl/dac_ser_adapter.sv
module dac_ser_adapter
  import dac_adapter_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CHAN_BIT = 2,
  localparam int WORD_W  = CTRL_W + DATA_W,
  localparam int LOW_CYC = frame_low_cycles(WORD_W),
  localparam int CNT_W   = $clog2(LOW_CYC + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              chan_sel,
  input  logic [CTRL_W-1:0] cfg_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy,
  output logic              frame_n,
  output logic              sclk,
  output logic              sdout
);
  logic [WORD_W-1:0] word;
  logic load, shift_en;

  dac_word_pack #(.CTRL_W(CTRL_W), .DATA_W(DATA_W), .CHAN_BIT(CHAN_BIT)) u_pack (
    .chan_sel(chan_sel), .cfg_in(cfg_in), .data_in(data_in), .word(word));

  dac_seq_ctrl #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .load(load), .shift_en(shift_en),
    .busy(busy), .frame_n(frame_n), .sclk(sclk));

  dac_shift_out #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .shift_en(shift_en),
    .word_in(word), .sdout(sdout));

  // checker-side count of frame low cycles
  logic [CNT_W-1:0] low_cnt;
  always_ff @(posedge clk) begin
    if (rst || frame_n) low_cnt <= '0;
    else                low_cnt <= low_cnt + 1'b1;
  end

  // R6
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_n) |-> low_cnt == CNT_W'(LOW_CYC));
  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk && frame_n));
  // R7
  busy_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $fell(frame_n));
  // R5
  data_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdout) |-> ($fell(sclk) || $fell(frame_n)));
  // R4
  sclk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |=> $fell(sclk));
endmodule

// File: tb/sim_dac_ser_adapter.sv
module sim_dac_ser_adapter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic chan_sel = 1'b0;
  logic [7:0] cfg_in = '0;
  logic [7:0] data_in = '0;
  logic busy, frame_n, sclk, sdout;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dac_ser_adapter u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .chan_sel(chan_sel),
    .cfg_in(cfg_in), .data_in(data_in), .busy(busy), .frame_n(frame_n),
    .sclk(sclk), .sdout(sdout));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic ch, input logic [7:0] c,
                                           input logic [7:0] d);
    logic [7:0] ctrl;
    ctrl = c;
    ctrl[2] = ch;
    return {ctrl, d};
  endfunction

  // one transfer; optionally disturb inputs mid-frame
  task automatic xfer(input logic ch, input logic [7:0] c, input logic [7:0] d,
                      input bit disturb, input string tag);
    logic [15:0] got = '0;
    int rises = 0, lows = 0, busys = 0, longest_hi = 0, hi = 0;
    logic prev_sclk = 1'b0;
    @(negedge clk);
    chan_sel = ch; cfg_in = c; data_in = d; wr_stb = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0) wr_stb = 1'b0;
      if (disturb && i == 6) begin
        wr_stb = 1'b1; chan_sel = ~ch; cfg_in = ~c; data_in = ~d;
      end
      if (disturb && i == 7) wr_stb = 1'b0;
      if (!frame_n) lows++;
      if (busy) busys++;
      if (sclk && !prev_sclk) begin
        rises++;
        got = {got[14:0], sdout};
      end
      hi = sclk ? hi + 1 : 0;
      if (hi > longest_hi) longest_hi = hi;
      prev_sclk = sclk;
    end
    check({"R2 word ", tag}, got, exp_word(ch, c, d));
    check({"R4 rises ", tag}, rises, 16);
    check({"R4 high width ", tag}, longest_hi, 1);
    check({"R6 frame low ", tag}, lows, 33);
    check({"R7 busy len ", tag}, busys, 33);
    if (disturb) check({"R8 ignored strobe ", tag}, {16'(got), 8'(lows)},
                       {exp_word(ch, c, d), 8'd33});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 frame_n", frame_n, 1);
    check("R1 sclk", sclk, 0);
    check("R1 sdout", sdout, 0);
    check("R1 busy", busy, 0);
  endtask

  task automatic t_patterns();
    xfer(1'b0, 8'h00, 8'hA5, 0, "alt A");
    xfer(1'b1, 8'h00, 8'h5A, 0, "alt B");
    xfer(1'b0, 8'h80, 8'h01, 0, "ends");
    xfer(1'b1, 8'hFF, 8'hFF, 0, "ones");
    xfer(1'b0, 8'hFF, 8'h00, 0, "R3 chan0 in ones");
    xfer(1'b1, 8'h00, 8'h00, 0, "R3 chan1 in zeros");
  endtask

  task automatic t_disturb();
    xfer(1'b1, 8'h3C, 8'hC3, 1, "R8 disturbed");
  endtask

  task automatic t_back_to_back();
    int first_low = -1, second_low = -1;
    logic prev_f = 1'b1;
    @(negedge clk);
    chan_sel = 0; cfg_in = 8'h11; data_in = 8'h22; wr_stb = 1'b1;
    for (int i = 0; i < 72; i++) begin
      @(negedge clk);
      if (!frame_n && prev_f) begin
        if (first_low < 0) first_low = i;
        else if (second_low < 0) second_low = i;
      end
      prev_f = frame_n;
    end
    wr_stb = 1'b0;
    check("R6 back-to-back period", second_low - first_low, 34);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk || !frame_n || busy) bad++;
    end
    check("R9 idle lines", bad, 0);
    check("R5 sdout after frame", sdout, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_patterns();
    t_disturb();
    t_idle();
    t_back_to_back();
    t_idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule